// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Selectable Write-Miss Policy

This block sits between a processor request port and a line-oriented memory port. It keeps a small direct-mapped array of 64-byte lines, each with its own valid bit, dirty bit and tag. Processor reads and writes carry a byte address and a length of 1 to 16 bytes. An access whose bytes run past the end of a line is cut into two line-sized sub-accesses. The lower-address part is always handled first, and the processor sees a single completion once both parts are done.

Writes that hit only update the cached copy and mark it modified. Modified lines go back to memory as whole lines, and only when they are evicted. A build-time parameter sets what a write miss does. With allocation on, the line is fetched (after writing back a modified victim), and the write is then merged into it. With allocation off, only the written bytes are sent to memory, and the cache array is left as it was.

Top module: `dcache_dm`

## Requirements
- R1: Address fields with the default sizes: byte offset is addr[5:0], line index is addr[9:6] (16 lines), tag is addr[31:10]. An access hits only when the indexed line is valid and its stored tag equals the address tag.
- R2: Reset marks every line invalid, so the first access to any line after reset fetches that line from memory.
- R3: A read that hits returns on cpu_rdata, at cpu_done, the bytes of the addressed range and zero in the bytes above the length. It causes no memory traffic.
- R4: A write hit replaces only the addressed bytes of the cached line and marks the line modified, with no memory traffic. A later eviction of that line carries the new bytes to memory.
- R5: Before a modified line is replaced, it is written to memory as one full-line transfer. That transfer has all 64 byte enables set and the line-aligned address rebuilt from the stored tag and the index. The fill starts only after this transfer ends.
- R6: A clean or invalid line is replaced by one line fill, with no write to memory.
- R7: With write allocation on, a write miss fetches the line, merges the write into it and leaves the line modified.
- R8: With write allocation off, a write miss issues exactly one memory write. Its address is line-aligned, its byte enables cover exactly the written bytes, and no line is fetched or changed.
- R9: An access that crosses a line boundary is done as two sub-accesses, the lower line first. cpu_ready stays low from acceptance until cpu_done. cpu_done is a one-cycle pulse, and cpu_ready returns high in the cycle after it.
- R10: A 16-byte write with write allocation on, crossing into a second line that misses, with a modified victim in the first line, moves exactly 192 bytes: one write-back and two fills.
- R11: A memory request keeps its address, direction and enables unchanged until mem_ready is high. The transfer completes in the cycle where mem_req and mem_ready are both high.
- R12: Byte k of cpu_wdata and cpu_rdata belongs to address addr+k. On mem_wdata, mem_rdata and mem_be, lane j (bits 8j+7:8j) belongs to byte j of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present, accepted when cpu_ready is high |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the first byte |
| cpu_len | input | 5 | Number of bytes, 1 to 16 |
| cpu_wdata | input | 128 | Write bytes, byte k for address addr+k |
| cpu_ready | output | 1 | Idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 128 | Read bytes, valid with cpu_done |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = write to memory, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_be | output | 64 | Byte enables per line byte |
| mem_wdata | output | 512 | Line data to memory |
| mem_ready | input | 1 | Memory completes the current request |
| mem_rdata | input | 512 | Line data from memory, valid with mem_ready |

## Verification
The hardest case to reach from the ports is a line-crossing write in which the lower line holds a modified line with another tag and the upper line holds a clean line with another tag. The crossing write then needs a write-back and two fills, or two separate partial writes, in a fixed order. A directed sequence sets up this case by first dirtying one line and loading its neighbour clean under one tag, then writing 16 bytes across their boundary under a second tag. Beyond that, every offset in a line is swept with crossing lengths, and thousands of pseudo-random accesses are confined to four tags per index, so that evictions, modified victims and crossings come up often. A shadow memory and a per-policy model of line state predict every transfer count, the first transfer address and the read data.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_WBACK,
    S_FILL,
    S_BYPASS,
    S_DONE
  } dc_state_t;
endpackage

// File: rtl/dc_part_calc.sv
// Splits a request into at most two line-local parts and aligns data for the
// selected part.
module dc_part_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_BYTES  = 16,
  parameter int LEN_W      = 5,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LW        = LINE_BYTES * 8,
  localparam int DW        = MAX_BYTES * 8
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    part_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [LW-1:0]           line_i,
  output logic [ADDR_W-OFF_W-1:0] part_line_o,
  output logic                    second_o,
  output logic [LINE_BYTES-1:0]   be_o,
  output logic [LW-1:0]           bemask_o,
  output logic [LW-1:0]           wline_o,
  output logic [DW-1:0]           rpart_o
);
  // bytes of the request that fit in the first line
  function automatic int head_len(int off, int len);
    int room;
    room = LINE_BYTES - off;
    return (len < room) ? len : room;
  endfunction

  // enable vector covering n bytes starting at lo
  function automatic logic [LINE_BYTES-1:0] span_be(int lo, int n);
    logic [LINE_BYTES-1:0] b;
    for (int i = 0; i < LINE_BYTES; i++) b[i] = (i >= lo) && (i < lo + n);
    return b;
  endfunction

  int off0, len_all, l0, l1, poff, plen, skip;

  always_comb begin
    off0        = int'(addr_i[OFF_W-1:0]);
    len_all     = int'(len_i);
    l0          = head_len(off0, len_all);
    l1          = len_all - l0;
    second_o    = (l1 != 0);
    part_line_o = addr_i[ADDR_W-1:OFF_W] + (ADDR_W - OFF_W)'(part_i);
    poff        = part_i ? 0 : off0;
    plen        = part_i ? l1 : l0;
    skip        = part_i ? l0 : 0;
    be_o        = span_be(poff, plen);
    wline_o     = (LW'(wdata_i) >> (8 * skip)) << (8 * poff);
  end

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_mask
    assign bemask_o[g*8 +: 8] = {8{be_o[g]}};
  end

  logic [LW-1:0] rsel;
  assign rsel    = ((line_i & bemask_o) >> (8 * poff)) << (8 * skip);
  assign rpart_o = rsel[DW-1:0];
endmodule

// File: rtl/dc_line_store.sv
// Line array: valid, dirty, tag and data per line, one write port.
module dc_line_store #(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 22,
  parameter int LW        = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [LW-1:0]    data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [LW-1:0]    wr_data_i,
  input  logic             wr_dirty_i
);
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LW-1:0]        data_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q[rd_idx_i];
  assign dirty_o = dirty_q[rd_idx_i];
  assign tag_o   = tag_q[rd_idx_i];
  assign data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/dcache_dm.sv
module dcache_dm
  import dc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 64,
  parameter int NUM_LINES      = 16,
  parameter int MAX_BYTES      = 16,
  parameter bit WRITE_ALLOCATE = 1'b1,
  localparam int LEN_W         = $clog2(MAX_BYTES + 1),
  localparam int DW            = MAX_BYTES * 8,
  localparam int LW            = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_valid,
  input  logic                  cpu_write,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [LEN_W-1:0]      cpu_len,
  input  logic [DW-1:0]         cpu_wdata,
  output logic                  cpu_ready,
  output logic                  cpu_done,
  output logic [DW-1:0]         cpu_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LINE_BYTES-1:0] mem_be,
  output logic [LW-1:0]         mem_wdata,
  input  logic                  mem_ready,
  input  logic [LW-1:0]         mem_rdata
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  dc_state_t         state_q;
  logic              req_write_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [LEN_W-1:0]  req_len_q;
  logic [DW-1:0]     req_wdata_q;
  logic [DW-1:0]     rdata_q;
  logic              part_q;

  // current part, from the splitter
  logic [ADDR_W-OFF_W-1:0] p_line;
  logic                    p_second;
  logic [LINE_BYTES-1:0]   p_be;
  logic [LW-1:0]           p_bemask, p_wline;
  logic [DW-1:0]           p_rdata;

  // line array view
  logic             s_valid, s_dirty;
  logic [TAG_W-1:0] s_tag;
  logic [LW-1:0]    s_data;
  logic             st_wr_en, st_wr_dirty;
  logic [LW-1:0]    st_wr_data;

  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] cur_tag;

  // named events for the checker
  logic st_lookup, st_wback, st_fill, st_bypass;
  logic ev_hit, ev_miss, ev_fill_done, ev_wb_done, ev_byp_done, ev_more;

  dc_part_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
  ) u_part (
    .addr_i(req_addr_q), .len_i(req_len_q), .part_i(part_q), .wdata_i(req_wdata_q),
    .line_i(s_data), .part_line_o(p_line), .second_o(p_second), .be_o(p_be),
    .bemask_o(p_bemask), .wline_o(p_wline), .rpart_o(p_rdata)
  );

  assign cur_idx = p_line[IDX_W-1:0];
  assign cur_tag = p_line[ADDR_W-OFF_W-1:IDX_W];

  dc_line_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LW(LW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx_i(cur_idx),
    .valid_o(s_valid), .dirty_o(s_dirty), .tag_o(s_tag), .data_o(s_data),
    .wr_en_i(st_wr_en), .wr_idx_i(cur_idx), .wr_tag_i(cur_tag),
    .wr_data_i(st_wr_data), .wr_dirty_i(st_wr_dirty)
  );

  assign st_lookup    = (state_q == S_LOOKUP);
  assign st_wback     = (state_q == S_WBACK);
  assign st_fill      = (state_q == S_FILL);
  assign st_bypass    = (state_q == S_BYPASS);
  assign ev_hit       = st_lookup && s_valid && (s_tag == cur_tag);
  assign ev_miss      = st_lookup && !ev_hit;
  assign ev_fill_done = st_fill && mem_ready;
  assign ev_wb_done   = st_wback && mem_ready;
  assign ev_byp_done  = st_bypass && mem_ready;
  assign ev_more      = !part_q && p_second;

  // array update: write hit merges, fill installs a clean line
  always_comb begin
    st_wr_en    = 1'b0;
    st_wr_dirty = 1'b0;
    st_wr_data  = mem_rdata;
    if (ev_hit && req_write_q) begin
      st_wr_en    = 1'b1;
      st_wr_dirty = 1'b1;
      st_wr_data  = (s_data & ~p_bemask) | (p_wline & p_bemask);
    end else if (ev_fill_done) begin
      st_wr_en = 1'b1;
    end
  end

  // memory port
  assign mem_req   = st_wback || st_fill || st_bypass;
  assign mem_we    = st_wback || st_bypass;
  assign mem_be    = st_bypass ? p_be : '1;
  assign mem_wdata = st_wback ? s_data : (st_bypass ? p_wline : '0);
  assign mem_addr  = st_wback ? {s_tag, cur_idx, {OFF_W{1'b0}}}
                              : {p_line, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      part_q      <= 1'b0;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_len_q   <= '0;
      req_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cpu_valid) begin
          req_write_q <= cpu_write;
          req_addr_q  <= cpu_addr;
          req_len_q   <= cpu_len;
          req_wdata_q <= cpu_wdata;
          part_q      <= 1'b0;
          rdata_q     <= '0;
          state_q     <= S_LOOKUP;
        end
        S_LOOKUP: begin
          if (ev_hit) begin
            if (!req_write_q) rdata_q <= rdata_q | p_rdata;
            if (ev_more) part_q  <= 1'b1;
            else         state_q <= S_DONE;
          end else if (req_write_q && !WRITE_ALLOCATE) begin
            state_q <= S_BYPASS;
          end else if (s_valid && s_dirty) begin
            state_q <= S_WBACK;
          end else begin
            state_q <= S_FILL;
          end
        end
        S_WBACK:  if (ev_wb_done)   state_q <= S_FILL;
        S_FILL:   if (ev_fill_done) state_q <= S_LOOKUP;
        S_BYPASS: if (ev_byp_done) begin
          if (ev_more) begin
            part_q  <= 1'b1;
            state_q <= S_LOOKUP;
          end else begin
            state_q <= S_DONE;
          end
        end
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign cpu_ready = (state_q == S_IDLE);
  assign cpu_done  = (state_q == S_DONE);
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dcache_dm_chk.sv
module dcache_dm_chk #(
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 64,
  parameter bit WRITE_ALLOCATE = 1'b1,
  localparam int OFF_W         = $clog2(LINE_BYTES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_ready,
  input logic                  cpu_done,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic                  mem_ready,
  input logic [ADDR_W-1:0]     mem_addr,
  input logic [LINE_BYTES-1:0] mem_be,
  input logic                  st_wback,
  input logic                  st_fill,
  input logic                  st_bypass,
  input logic                  part_q,
  input logic                  req_write_q
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

  a_r5_wb_full_line: assert property (@(posedge clk) disable iff (!rst_n)
    st_wback |-> mem_we && (&mem_be) && (mem_addr[OFF_W-1:0] == '0));

  a_r5_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    st_wback && mem_ready |=> st_fill);

  a_r7_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    st_fill |-> !mem_we && (mem_addr[OFF_W-1:0] == '0));

  a_r8_bypass_partial: assert property (@(posedge clk) disable iff (!rst_n)
    st_bypass |-> mem_we && (mem_be != '0) && !(&mem_be) && (mem_addr[OFF_W-1:0] == '0));

  if (!WRITE_ALLOCATE) begin : g_nwa
    a_r8_no_write_fill: assert property (@(posedge clk) disable iff (!rst_n)
      st_fill |-> !req_write_q);
  end

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req && !cpu_done);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> cpu_ready && !cpu_done);

  a_r9_part_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(part_q) |-> $past(cpu_ready));
endmodule

bind dcache_dm dcache_dm_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WRITE_ALLOCATE(WRITE_ALLOCATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_be(mem_be), .st_wback(st_wback), .st_fill(st_fill), .st_bypass(st_bypass),
  .part_q(part_q), .req_write_q(req_write_q)
);

// File: tb/tb_dcache_dm.sv
// Memory model: answers each request one cycle later and counts traffic.
module tb_mem (
  input  logic         clk,
  input  logic         mem_req,
  input  logic         mem_we,
  input  logic [31:0]  mem_addr,
  input  logic [63:0]  mem_be,
  input  logic [511:0] mem_wdata,
  output logic         mem_ready,
  output logic [511:0] mem_rdata
);
  int n_fill = 0, n_wb = 0, n_part = 0, n_pbytes = 0, n_ops = 0;
  logic [31:0] log_a [0:7];
  logic [7:0]  m [0:16383];

  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
    for (int a = 0; a < 16384; a++) m[a] = 8'((a * 29) + ((a >> 6) * 7) + 11);
  end

  always @(posedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
    end else if (mem_req) begin
      int base;
      logic [511:0] t;
      base = int'({mem_addr[13:6], 6'b0});
      mem_ready <= 1'b1;
      log_a[n_ops[2:0]] <= mem_addr;
      n_ops <= n_ops + 1;
      if (!mem_we) begin
        for (int j = 0; j < 64; j++) t[j*8 +: 8] = m[base + j];
        mem_rdata <= t;
        n_fill <= n_fill + 1;
      end else begin
        for (int j = 0; j < 64; j++) if (mem_be[j]) m[base + j] <= mem_wdata[j*8 +: 8];
        if (&mem_be) n_wb <= n_wb + 1;
        else begin
          n_part   <= n_part + 1;
          n_pbytes <= n_pbytes + $countones(mem_be);
        end
      end
    end
  end
endmodule

module tb_dcache_dm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         c_valid = 1'b0, c_write = 1'b0;
  logic [31:0]  c_addr = '0;
  logic [4:0]   c_len = 5'd1;
  logic [127:0] c_wdata = '0;

  logic         rdy0, dn0, mq0, mw0, mr0, rdy1, dn1, mq1, mw1, mr1;
  logic [127:0] rd0, rd1;
  logic [31:0]  ma0, ma1;
  logic [63:0]  mb0, mb1;
  logic [511:0] mwd0, mwd1, mrd0, mrd1;

  dcache_dm #(.WRITE_ALLOCATE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(c_valid), .cpu_write(c_write), .cpu_addr(c_addr),
    .cpu_len(c_len), .cpu_wdata(c_wdata), .cpu_ready(rdy0), .cpu_done(dn0), .cpu_rdata(rd0),
    .mem_req(mq0), .mem_we(mw0), .mem_addr(ma0), .mem_be(mb0), .mem_wdata(mwd0),
    .mem_ready(mr0), .mem_rdata(mrd0));
  dcache_dm #(.WRITE_ALLOCATE(1'b0)) dut_nwa (
    .clk(clk), .rst_n(rst_n), .cpu_valid(c_valid), .cpu_write(c_write), .cpu_addr(c_addr),
    .cpu_len(c_len), .cpu_wdata(c_wdata), .cpu_ready(rdy1), .cpu_done(dn1), .cpu_rdata(rd1),
    .mem_req(mq1), .mem_we(mw1), .mem_addr(ma1), .mem_be(mb1), .mem_wdata(mwd1),
    .mem_ready(mr1), .mem_rdata(mrd1));
  tb_mem u_mem0 (.clk(clk), .mem_req(mq0), .mem_we(mw0), .mem_addr(ma0), .mem_be(mb0),
                 .mem_wdata(mwd0), .mem_ready(mr0), .mem_rdata(mrd0));
  tb_mem u_mem1 (.clk(clk), .mem_req(mq1), .mem_we(mw1), .mem_addr(ma1), .mem_be(mb1),
                 .mem_wdata(mwd1), .mem_ready(mr1), .mem_rdata(mrd1));

  int n_chk = 0, n_fail = 0;
  logic [7:0]  sh [0:16383];
  bit          rv [2][16];
  bit          rdty [2][16];
  logic [21:0] rt [2][16];
  int ef[2], ew[2], ep[2], eb[2], fa[2];
  bit fs[2];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic note(int k, int a);
    if (!fs[k]) begin fs[k] = 1; fa[k] = a; end
  endtask

  // expected effect of one line-local part on policy k (0 allocate, 1 bypass)
  task automatic ref_part(int k, int a, int plen, bit we);
    int idx;
    logic [21:0] tg;
    idx = (a >> 6) & 15;
    tg  = 22'(a >> 10);
    if (rv[k][idx] && rt[k][idx] == tg) begin
      if (we) rdty[k][idx] = 1;
    end else if (we && k == 1) begin
      ep[k]++; eb[k] += plen; note(k, a & ~63);
    end else begin
      if (rv[k][idx] && rdty[k][idx]) begin
        ew[k]++; note(k, (int'(rt[k][idx]) << 10) | (idx << 6));
      end
      ef[k]++; note(k, a & ~63);
      rv[k][idx] = 1; rt[k][idx] = tg; rdty[k][idx] = we;
    end
  endtask

  task automatic access(bit we, int a, int len, logic [127:0] wd);
    int l0, l1, cyc;
    int sf[2], sw[2], sp[2], sb[2], so[2], bad[2];
    bit d0, d1;
    logic [127:0] er, g0, g1;
    l0 = (len < 64 - (a % 64)) ? len : 64 - (a % 64);
    l1 = len - l0;
    for (int k = 0; k < 2; k++) begin
      ef[k] = 0; ew[k] = 0; ep[k] = 0; eb[k] = 0; fs[k] = 0; fa[k] = 0; bad[k] = 0;
      ref_part(k, a, l0, we);
      if (l1 != 0) ref_part(k, (a & ~63) + 64, l1, we);
    end
    er = '0;
    for (int i = 0; i < len; i++) begin
      er[i*8 +: 8] = sh[a + i];
      if (we) sh[a + i] = wd[i*8 +: 8];
    end
    sf[0] = u_mem0.n_fill; sw[0] = u_mem0.n_wb; sp[0] = u_mem0.n_part;
    sb[0] = u_mem0.n_pbytes; so[0] = u_mem0.n_ops;
    sf[1] = u_mem1.n_fill; sw[1] = u_mem1.n_wb; sp[1] = u_mem1.n_part;
    sb[1] = u_mem1.n_pbytes; so[1] = u_mem1.n_ops;
    @(negedge clk);
    c_valid = 1'b1; c_write = we; c_addr = 32'(a); c_len = 5'(len); c_wdata = wd;
    @(negedge clk);
    c_valid = 1'b0;
    d0 = 0; d1 = 0; cyc = 0; g0 = '0; g1 = '0;
    while (!(d0 && d1) && cyc < 400) begin
      if (!d0) begin
        if (dn0) begin d0 = 1; g0 = rd0; end else if (rdy0) bad[0]++;
      end
      if (!d1) begin
        if (dn1) begin d1 = 1; g1 = rd1; end else if (rdy1) bad[1]++;
      end
      if (!(d0 && d1)) begin @(negedge clk); cyc++; end
    end
    chk("R9 access completes", {126'b0, d1, d0}, 128'd3);
    for (int k = 0; k < 2; k++) begin
      int nf, nw, np, nb, fo;
      if (k == 0) begin
        nf = u_mem0.n_fill; nw = u_mem0.n_wb; np = u_mem0.n_part; nb = u_mem0.n_pbytes;
        fo = int'(u_mem0.log_a[so[0] % 8]);
      end else begin
        nf = u_mem1.n_fill; nw = u_mem1.n_wb; np = u_mem1.n_part; nb = u_mem1.n_pbytes;
        fo = int'(u_mem1.log_a[so[1] % 8]);
      end
      chk("R1 R2 R6 R7 line fills", 128'(nf - sf[k]), 128'(ef[k]));
      chk("R4 R5 write-backs", 128'(nw - sw[k]), 128'(ew[k]));
      chk("R8 partial writes", 128'(np - sp[k]), 128'(ep[k]));
      chk("R8 R12 partial bytes", 128'(nb - sb[k]), 128'(eb[k]));
      if (fs[k]) chk("R9 R11 first transfer address", 128'(fo), 128'(fa[k]));
      chk("R9 ready low while busy", 128'(bad[k]), 128'd0);
    end
    if (!we) begin
      chk("R3 R12 read data allocate", g0, er);
      chk("R3 R12 read data bypass", g1, er);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16384; a++) sh[a] = 8'((a * 29) + ((a >> 6) * 7) + 11);
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 16; i++) begin rv[k][i] = 0; rdty[k][i] = 0; rt[k][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: idle after reset
    chk("R2 ready after reset", {126'b0, rdy1, rdy0}, 128'd3);
    chk("R2 no memory request after reset", {126'b0, mq1, mq0}, 128'd0);
    chk("R9 no done after reset", {126'b0, dn1, dn0}, 128'd0);

    // every offset, crossing lengths included (R9, R12)
    for (int off = 0; off < 64; off++) begin
      int a;
      a = 1024 * (off % 4) + 128 + off;
      access(1'b1, a, 16, {rnd(), rnd(), rnd(), rnd()});
      access(1'b0, a, 16, '0);
      access(1'b0, a, 1 + (off % 16), '0);
    end

    // R10: modified lower victim, clean upper victim, crossing write
    begin
      int f0, w0, b1;
      access(1'b1, 32'h2000 + 5 * 64, 4, 128'hA5A5_5A5A);
      access(1'b0, 32'h2000 + 6 * 64, 8, '0);
      f0 = u_mem0.n_fill; w0 = u_mem0.n_wb; b1 = u_mem1.n_pbytes;
      access(1'b1, 32'h3000 + 5 * 64 + 56, 16, {rnd(), rnd(), rnd(), rnd()});
      chk("R10 allocate traffic bytes", 128'(64 * ((u_mem0.n_fill - f0) + (u_mem0.n_wb - w0))), 128'd192);
      chk("R8 R10 bypass traffic bytes", 128'(u_mem1.n_pbytes - b1), 128'd16);
      access(1'b0, 32'h3000 + 5 * 64 + 56, 16, '0);
      access(1'b0, 32'h2000 + 5 * 64, 4, '0);
    end

    // mixed pseudo-random traffic, four tags per index
    for (int n = 0; n < 3000; n++) begin
      int a, len;
      bit we;
      a   = int'(rnd() % 4096);
      len = 1 + int'(rnd() % 16);
      we  = rnd() % 2 == 0;
      access(we, a, len, {rnd(), rnd(), rnd(), rnd()});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule